// File: doc/BRIEF.md
# Station-Address PROM Read Responder with Soft-Reset Port

This block answers I/O read cycles on a PC-style expansion bus for a 16-byte, 8-bit station-address PROM. The PROM shares a private data bus with other agents, so when a read to the PROM window is seen, the block first requests that private bus. Meanwhile it pulls the bus-ready line low so that the host stretches the cycle. When the grant arrives, the block selects the PROM, releases the ready line and drives the PROM byte onto the low half of the system data bus only. The access always completes as an 8-bit cycle. The 16-bit select line stays inactive.

A second address decodes as a reset port. A read of that port produces a one-cycle controller soft-reset pulse. That pulse is a separate output, so any link-state logic that must keep its pass/fail status is simply not wired to it. A write to the same port does nothing. All outputs come from registers except the low data byte, which is a gated copy of the PROM data lines. That gating lets the byte drive turn off one clock after the read strobe drops.

Top module: `isa_prom_slave`

## Requirements
- R1: A cycle starts when, at a clock edge, `bus_aen` is 0, `bus_rd` is 1 and `bus_addr` lies in [PROM_BASE, PROM_BASE+15]. After that edge `io_ready` is 0 and `pbus_req` is 1. The same address with `bus_aen`=1, or with only `bus_wr`=1, changes no output.
- R2: While a started access has not been granted and `bus_rd` stays 1, `io_ready` stays 0.
- R3: At the first edge after the start at which `pbus_gnt` is 1, the block does three things. It sets `prom_sel`=1, `lo_oe`=1 and `io_ready`=1. It drives `prom_idx`, which equals `bus_addr[3:0]` captured at the start. It makes `sd_lo` equal `prom_data`.
- R4: `io_cs16` is 0 at all times. `sd_lo` is 0 whenever `lo_oe` is 0.
- R5: At the first edge with `bus_rd`=0, the access ends. After that edge `prom_sel`, `lo_oe` and `pbus_req` are 0 and `io_ready` is 1. This applies whether or not the access was granted.
- R6: A read of address RST_PORT (with `bus_aen`=0) gives exactly one `soft_rst` pulse, one clock wide, in the cycle after the start edge. This holds however long the read lasts.
- R7: A write to RST_PORT, including one that follows a reset read, never raises `soft_rst` and changes no output.
- R8: During and right after reset, `io_ready`=1 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low hard reset |
| bus_aen | input | 1 | Address-enable; 1 marks a DMA cycle, which is ignored |
| bus_addr | input | ADDR_W | I/O address |
| bus_rd | input | 1 | I/O read strobe, active high |
| bus_wr | input | 1 | I/O write strobe, active high |
| pbus_gnt | input | 1 | Private data bus granted |
| prom_data | input | 8 | PROM data lines |
| io_ready | output | 1 | Bus ready; 0 stretches the cycle |
| io_cs16 | output | 1 | 16-bit cycle select, always 0 |
| pbus_req | output | 1 | Private data bus request |
| prom_sel | output | 1 | PROM chip select |
| prom_idx | output | 4 | PROM byte index |
| lo_oe | output | 1 | Low data byte drive enable |
| sd_lo | output | 8 | Low data byte value |
| soft_rst | output | 1 | Controller soft-reset pulse |

## Verification
Reads to the PROM window are run with several grant delays. Zero delay tells apart a block that skips the stretch phase. A long delay shows that ready is held low for the whole wait. A read dropped before any grant checks that the block backs out without selecting the PROM. Reads of the first and last window bytes, and of the addresses just outside the window, find off-by-one errors in the decode. Cycles with AEN high and writes to the window show that the start qualifiers are really applied. Long reset reads, and a reset read followed by a write, tell a single pulse apart from a level, and a read trigger apart from a write trigger.

// File: rtl/isa_prom_pkg.sv
package isa_prom_pkg;
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_WAIT  = 2'd1,
        CYC_DRIVE = 2'd2,
        CYC_RHOLD = 2'd3
    } cyc_state_e;
endpackage

// File: rtl/isa_slave_decode.sv
module isa_slave_decode #(
    parameter int ADDR_W     = 10,
    parameter int IDX_W      = 4,
    parameter logic [ADDR_W-1:0] PROM_BASE = 10'h300,
    parameter logic [ADDR_W-1:0] RST_PORT  = 10'h314
) (
    input  logic              bus_aen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic              prom_hit,
    output logic              rst_hit
);
    localparam int UP_W = ADDR_W - IDX_W;

    logic in_window;
    logic is_rst;
    logic rd_cycle;

    always_comb begin
        in_window = (bus_addr[ADDR_W-1:IDX_W] == PROM_BASE[ADDR_W-1:IDX_W]);
        is_rst    = (bus_addr == RST_PORT);
        rd_cycle  = !bus_aen && bus_rd && !bus_wr;
        prom_hit  = rd_cycle && in_window;
        rst_hit   = rd_cycle && is_rst && !in_window;
    end

    initial begin
        assert (UP_W > 0);
    end
endmodule

// File: rtl/isa_cycle_fsm.sv
module isa_cycle_fsm
    import isa_prom_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prom_hit,
    input  logic              rst_hit,
    input  logic              bus_rd,
    input  logic [IDX_W-1:0]  addr_idx,
    input  logic              pbus_gnt,
    output logic              io_ready,
    output logic              pbus_req,
    output logic              prom_sel,
    output logic              lo_oe,
    output logic [IDX_W-1:0]  prom_idx,
    output logic              soft_rst
);
    typedef struct packed {
        cyc_state_e         st;
        logic               ready;
        logic               req;
        logic               sel;
        logic               oe;
        logic               rst;
        logic [IDX_W-1:0]   idx;
    } cyc_regs_t;

    localparam cyc_regs_t REGS_RESET = '{
        st: CYC_IDLE, ready: 1'b1, req: 1'b0, sel: 1'b0,
        oe: 1'b0, rst: 1'b0, idx: '0
    };

    cyc_regs_t regs_d, regs_q;

    always_comb begin
        regs_d     = regs_q;
        regs_d.rst = 1'b0;
        unique case (regs_q.st)
            CYC_IDLE: begin
                if (prom_hit) begin
                    regs_d.st    = CYC_WAIT;
                    regs_d.ready = 1'b0;
                    regs_d.req   = 1'b1;
                    regs_d.idx   = addr_idx;
                end else if (rst_hit) begin
                    regs_d.st  = CYC_RHOLD;
                    regs_d.rst = 1'b1;
                end
            end
            CYC_WAIT: begin
                if (!bus_rd) begin
                    regs_d.st    = CYC_IDLE;
                    regs_d.ready = 1'b1;
                    regs_d.req   = 1'b0;
                end else if (pbus_gnt) begin
                    regs_d.st    = CYC_DRIVE;
                    regs_d.ready = 1'b1;
                    regs_d.sel   = 1'b1;
                    regs_d.oe    = 1'b1;
                end
            end
            CYC_DRIVE: begin
                if (!bus_rd) begin
                    regs_d.st  = CYC_IDLE;
                    regs_d.req = 1'b0;
                    regs_d.sel = 1'b0;
                    regs_d.oe  = 1'b0;
                end
            end
            CYC_RHOLD: begin
                if (!bus_rd) begin
                    regs_d.st = CYC_IDLE;
                end
            end
            default: regs_d = REGS_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RESET;
        else        regs_q <= regs_d;
    end

    assign io_ready = regs_q.ready;
    assign pbus_req = regs_q.req;
    assign prom_sel = regs_q.sel;
    assign lo_oe    = regs_q.oe;
    assign prom_idx = regs_q.idx;
    assign soft_rst = regs_q.rst;

    assert_stretch_on_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pbus_req && !prom_sel) |-> !io_ready);

    assert_sel_after_gnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prom_sel) |-> ($past(pbus_gnt) && $past(pbus_req)));

    assert_end_on_rd_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pbus_req && !bus_rd) |=> (!prom_sel && !lo_oe && !pbus_req && io_ready));

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

    assert_pulse_from_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> $past(bus_rd));

    assert_oe_with_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lo_oe |-> (prom_sel && io_ready));
endmodule

// File: rtl/isa_lo_byte_path.sv
module isa_lo_byte_path #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] prom_data,
    input  logic              lo_oe,
    output logic [DATA_W-1:0] sd_lo
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign sd_lo[b] = prom_data[b] & lo_oe;
    end
endmodule

// File: rtl/isa_prom_slave.sv
module isa_prom_slave #(
    parameter int ADDR_W     = 10,
    parameter int PROM_BYTES = 16,
    parameter logic [ADDR_W-1:0] PROM_BASE = 10'h300,
    parameter logic [ADDR_W-1:0] RST_PORT  = 10'h314
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_aen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              pbus_gnt,
    input  logic [7:0]        prom_data,
    output logic              io_ready,
    output logic              io_cs16,
    output logic              pbus_req,
    output logic              prom_sel,
    output logic [$clog2(PROM_BYTES)-1:0] prom_idx,
    output logic              lo_oe,
    output logic [7:0]        sd_lo,
    output logic              soft_rst
);
    localparam int IDX_W = $clog2(PROM_BYTES);

    logic prom_hit;
    logic rst_hit;

    isa_slave_decode #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W),
        .PROM_BASE(PROM_BASE), .RST_PORT(RST_PORT)
    ) u_dec (
        .bus_aen (bus_aen),
        .bus_addr(bus_addr),
        .bus_rd  (bus_rd),
        .bus_wr  (bus_wr),
        .prom_hit(prom_hit),
        .rst_hit (rst_hit)
    );

    isa_cycle_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .prom_hit(prom_hit),
        .rst_hit (rst_hit),
        .bus_rd  (bus_rd),
        .addr_idx(bus_addr[IDX_W-1:0]),
        .pbus_gnt(pbus_gnt),
        .io_ready(io_ready),
        .pbus_req(pbus_req),
        .prom_sel(prom_sel),
        .lo_oe   (lo_oe),
        .prom_idx(prom_idx),
        .soft_rst(soft_rst)
    );

    isa_lo_byte_path #(.DATA_W(8)) u_path (
        .prom_data(prom_data),
        .lo_oe    (lo_oe),
        .sd_lo    (sd_lo)
    );

    assign io_cs16 = 1'b0;

    assert_oe_gates_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_oe |-> (sd_lo == 8'h00));
endmodule

// File: tb/tb_isa_prom_slave.sv
module tb_isa_prom_slave;
    localparam logic [9:0] BASE = 10'h300;
    localparam logic [9:0] RSTP = 10'h314;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_aen = 1'b1;
    logic [9:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic       pbus_gnt = 1'b0;
    logic [7:0] prom_data;
    logic       io_ready, io_cs16, pbus_req, prom_sel, lo_oe, soft_rst;
    logic [3:0] prom_idx;
    logic [7:0] sd_lo;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int pulses = 0;

    // reference model state
    int m_st = 0;
    bit e_ready = 1, e_req = 0, e_sel = 0, e_oe = 0, e_rst = 0;
    int e_idx = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] rom_byte(input int i);
        return 8'(8'h35 ^ (i * 8'd17 + 8'd3));
    endfunction

    assign prom_data = rom_byte(int'(prom_idx));

    isa_prom_slave dut (
        .clk(clk), .rst_n(rst_n), .bus_aen(bus_aen), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .pbus_gnt(pbus_gnt),
        .prom_data(prom_data), .io_ready(io_ready), .io_cs16(io_cs16),
        .pbus_req(pbus_req), .prom_sel(prom_sel), .prom_idx(prom_idx),
        .lo_oe(lo_oe), .sd_lo(sd_lo), .soft_rst(soft_rst)
    );

    // behavioural model of R1..R8
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; e_ready = 1; e_req = 0; e_sel = 0; e_oe = 0; e_rst = 0; e_idx = 0;
        end else begin
            bit rdc;
            rdc = !bus_aen && bus_rd && !bus_wr;
            e_rst = 0;
            case (m_st)
                0: if (rdc && bus_addr >= BASE && bus_addr <= BASE + 15) begin
                       m_st = 1; e_ready = 0; e_req = 1; e_idx = int'(bus_addr) - int'(BASE);
                   end else if (rdc && bus_addr == RSTP) begin
                       m_st = 3; e_rst = 1;
                   end
                1: if (!bus_rd) begin m_st = 0; e_ready = 1; e_req = 0; end
                   else if (pbus_gnt) begin m_st = 2; e_ready = 1; e_sel = 1; e_oe = 1; end
                2: if (!bus_rd) begin m_st = 0; e_req = 0; e_sel = 0; e_oe = 0; end
                default: if (!bus_rd) m_st = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1/R2 io_ready", int'(io_ready), int'(e_ready));
            chk("R1/R5 pbus_req", int'(pbus_req), int'(e_req));
            chk("R3/R5 prom_sel", int'(prom_sel), int'(e_sel));
            chk("R3/R5 lo_oe", int'(lo_oe), int'(e_oe));
            chk("R4 io_cs16", int'(io_cs16), 0);
            chk("R4 sd_lo", int'(sd_lo), e_oe ? int'(rom_byte(e_idx)) : 0);
            if (e_sel) chk("R3 prom_idx", int'(prom_idx), e_idx);
            chk("R6/R7 soft_rst", int'(soft_rst), int'(e_rst));
            if (soft_rst) pulses++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic prom_read(input logic [9:0] a, input int gnt_dly, input int hold, input bit aen);
        @(negedge clk);
        bus_aen = aen; bus_addr = a; bus_rd = 1;
        idle(gnt_dly);
        pbus_gnt = 1;
        idle(hold);
        bus_rd = 0; pbus_gnt = 0; bus_aen = 1;
        idle(2);
    endtask

    task automatic port_write(input logic [9:0] a);
        @(negedge clk);
        bus_aen = 0; bus_addr = a; bus_wr = 1;
        idle(3);
        bus_wr = 0; bus_aen = 1;
        idle(2);
    endtask

    initial begin
        idle(2);
        // R8: reset values
        chk("R8 io_ready", int'(io_ready), 1);
        chk("R8 prom_sel", int'(prom_sel), 0);
        chk("R8 pbus_req", int'(pbus_req), 0);
        chk("R8 soft_rst", int'(soft_rst), 0);
        rst_n = 1;
        idle(2);
        chk("R8 io_ready after reset", int'(io_ready), 1);

        // R1/R3: immediate grant, first byte
        prom_read(BASE, 0, 3, 0);
        // R2: long wait, last byte
        prom_read(BASE + 15, 9, 2, 0);
        // directed R2 check in the middle of a wait
        @(negedge clk);
        bus_aen = 0; bus_addr = BASE + 7; bus_rd = 1;
        idle(4);
        chk("R2 ready low while waiting", int'(io_ready), 0);
        pbus_gnt = 1;
        idle(1);
        chk("R3 select after grant", int'(prom_sel), 1);
        chk("R3 byte value", int'(sd_lo), int'(rom_byte(7)));
        bus_rd = 0; pbus_gnt = 0; bus_aen = 1;
        idle(1);
        chk("R5 drive off after rd drop", int'(lo_oe), 0);
        idle(1);
        // R5: read abandoned before grant
        @(negedge clk);
        bus_aen = 0; bus_addr = BASE + 3; bus_rd = 1;
        idle(3);
        bus_rd = 0; bus_aen = 1;
        idle(1);
        chk("R5 abandon ready", int'(io_ready), 1);
        chk("R5 abandon req", int'(pbus_req), 0);
        idle(2);
        // R1: out-of-window neighbours, aen high, write to window
        prom_read(BASE - 1, 1, 2, 0);
        prom_read(BASE + 16, 1, 2, 0);
        prom_read(BASE + 2, 1, 2, 1);
        port_write(BASE + 5);
        chk("R1 ignored accesses leave ready high", int'(io_ready), 1);
        // R6: reset read, short and long
        pulses = 0;
        prom_read(RSTP, 0, 1, 0);
        prom_read(RSTP, 0, 8, 0);
        chk("R6 one pulse per reset read", pulses, 2);
        // R7: write following a reset read
        pulses = 0;
        prom_read(RSTP, 0, 1, 0);
        port_write(RSTP);
        chk("R7 write after reset read adds no pulse", pulses, 1);
        port_write(RSTP);
        chk("R7 lone write no pulse", pulses, 1);
        // mixed sweep of bytes and grant delays
        for (int i = 0; i < 16; i++) prom_read(BASE + 10'(i), i % 4, 1 + i % 3, 0);
        idle(3);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule